// File: doc/BRIEF.md
# Software-Refilled Address Translation Unit

This block turns 32-bit virtual addresses into 30-bit physical addresses for a processor that uses 4 KB pages. A fully associative table of 32 page mappings serves the lower three quarters of the virtual space. The top quarter is never translated: it is mapped straight onto RAM, ROM and I/O windows. The unit has no hardware table walker. When a lookup fails it reports an exception code, and software refills the table through four management commands: probe, write-indexed, write-random and read-indexed.

The unit holds four special registers that software reads and writes through a simple select/data port: a slot index, a page register, a frame register and a faulting-address register. Each entry's valid and write-permission flags are consulted only after an entry has matched, so an invalid entry still counts as a hit for the purpose of fault classification. A free-running counter chooses the slot for write-random. It skips the lowest four slots, which keeps pinned mappings resident. Address translation is combinational. Register updates caused by faults or commands take effect at the next clock edge.

Top module: `mmu_xlate`

## Requirements
- R1: After reset the index, page, frame and fault-address registers read 0, and an access anywhere below 0xC0000000 misses.
- R2: An untranslated access (address 0xC0000000 and up, not faulting otherwise) yields physical address 0x00000000+(va-0xC0000000) for va below 0xE0000000, 0x20000000+(va-0xE0000000) for va below 0xF0000000, and 0x30000000+(va-0xF0000000) above that, with no fault.
- R3: A misaligned access (size 1 = halfword with va[0]=1, size 2 or 3 = word with va[1:0]≠0; size 0 = byte never misaligned) faults with code 24, ahead of every other fault.
- R4: In user mode (acc_user=1), an aligned access with va[31]=1 faults with code 25, ahead of all table faults.
- R5: When no entry's page equals va[31:12], the access faults with code 21, and acc_umiss is 1 exactly when va[31]=0.
- R6: A matching entry with valid=0 faults with code 23, for loads and stores alike.
- R7: A store that matches a valid entry whose write flag is 0 faults with code 22. A load through the same entry succeeds.
- R8: A load or permitted store that hits a valid entry returns {frame, va[11:0]}. When several entries match, the lowest-numbered one is used.
- R9: On any accepted faulting access the fault-address register takes the full va. On codes 21 to 23 the page register also takes va with its low 12 bits cleared. On codes 24 and 25 the page register is left unchanged.
- R10: Probe searches for the page register's page. On a hit the index register reads {bit31=0, slot number in bits 4:0}. On a miss bit 31 is set.
- R11: Register selects are 0 index, 1 page, 2 frame, 3 fault address. The page register holds bits 31:12. The frame register holds the frame in bits 29:12, the write flag in bit 1 and the valid flag in bit 0. Command 3 (write-indexed) stores page and frame into the slot named by index bits 4:0. Command 2 (read-indexed) loads that slot back into the page and frame registers.
- R12: Command 1 (write-random) stores into a slot between 4 and 31 and never touches slots 0 to 3. Command 0 is probe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_user | input | 1 | Access issued in user mode |
| acc_paddr | output | 30 | Physical address, 0 when faulting |
| acc_fault | output | 1 | Access raises an exception |
| acc_code | output | 5 | Exception code, 0 when none |
| acc_umiss | output | 1 | Table miss on the user half |
| cmd_valid | input | 1 | Management command this cycle |
| cmd_op | input | 2 | 0 probe, 1 write-random, 2 read-indexed, 3 write-indexed |
| sr_we | input | 1 | Write the selected special register |
| sr_sel | input | 2 | Special register select |
| sr_wdata | input | 32 | Special register write data |
| sr_rdata | output | 32 | Selected special register contents |

## Verification
The bench fills every slot by index with pages that mix the user and kernel halves, and frames that cover all four combinations of the valid and write flags. It then sends a load, a store and a user-mode load into each slot. This separates hit, invalid, write-protect and privilege results, and it distinguishes slot-number and flag-bit mix-ups. A sweep over every access size and low-address pair separates alignment rules per size. Fixed addresses at the edges of the three untranslated windows expose window-base errors. Repeated write-random and probe pairs show where each random write landed, and they confirm that the four pinned slots still answer probes afterwards.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 30;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = PA_W - PAGE_BITS;
    localparam int SLOTS     = 32;
    localparam int PINNED    = 4;
    localparam int IDX_W     = $clog2(SLOTS);

    typedef enum logic [1:0] {
        OP_PROBE   = 2'd0,
        OP_WR_RAND = 2'd1,
        OP_RD_IDX  = 2'd2,
        OP_WR_IDX  = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_PAGE  = 2'd1,
        SEL_FRAME = 2'd2,
        SEL_FADDR = 2'd3
    } sr_sel_e;

    typedef enum logic [4:0] {
        EXC_NONE    = 5'd0,
        EXC_MISS    = 5'd21,
        EXC_WPROT   = 5'd22,
        EXC_INVALID = 5'd23,
        EXC_ALIGN   = 5'd24,
        EXC_PRIV    = 5'd25
    } exc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             wr_ok;
        logic             valid;
    } tlb_entry_t;

    // size 0 byte, 1 halfword, 2/3 word
    function automatic logic is_misaligned(input logic [1:0] lo, input logic [1:0] sz);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            default: return lo != 2'b00;
        endcase
    endfunction

    function automatic logic is_tlb_exc(input exc_e c);
        return (c == EXC_MISS) || (c == EXC_WPROT) || (c == EXC_INVALID);
    endfunction
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
    parameter int N     = tlb_pkg::SLOTS,
    parameter int LOW   = tlb_pkg::PINNED,
    localparam int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst || idx == IW'(N - 1)) idx <= IW'(LOW);
        else                          idx <= idx + 1'b1;
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N  = SLOTS,
    localparam int IW = $clog2(N),
    localparam int RW = VPN_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_valid,
    output logic             lk_wr_ok,
    input  logic [VPN_W-1:0] pr_vpn,
    output logic             pr_hit,
    output logic [IW-1:0]    pr_idx,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  tlb_entry_t       wr_data,
    input  logic [IW-1:0]    rd_idx,
    output tlb_entry_t       rd_entry
);
    tlb_entry_t      ent_q [N];
    logic [N-1:0]    lk_match;
    logic [N-1:0]    pr_match;
    logic [IW-1:0]   lk_idx;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // reset pages sit in the untranslated window, so they never hit a lookup
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g].vpn   <= {2'b11, RW'(g)};
                ent_q[g].pfn   <= '0;
                ent_q[g].wr_ok <= 1'b0;
                ent_q[g].valid <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent_q[g] <= wr_data;
            end
        end
        assign lk_match[g] = (ent_q[g].vpn == lk_vpn);
        assign pr_match[g] = (ent_q[g].vpn == pr_vpn);
    end

    always_comb begin
        lk_idx = '0;
        pr_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx = IW'(i);
            if (pr_match[i]) pr_idx = IW'(i);
        end
    end

    assign lk_hit   = |lk_match;
    assign pr_hit   = |pr_match;
    assign lk_pfn   = ent_q[lk_idx].pfn;
    assign lk_valid = ent_q[lk_idx].valid;
    assign lk_wr_ok = ent_q[lk_idx].wr_ok;
    assign rd_entry = ent_q[rd_idx];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [31:0]     acc_vaddr,
    input  logic            acc_store,
    input  logic [1:0]      acc_size,
    input  logic            acc_user,
    output logic [PA_W-1:0] acc_paddr,
    output logic            acc_fault,
    output logic [4:0]      acc_code,
    output logic            acc_umiss,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic            sr_we,
    input  logic [1:0]      sr_sel,
    input  logic [31:0]     sr_wdata,
    output logic [31:0]     sr_rdata
);
    logic             nf_q;
    logic [IDX_W-1:0] idx_q;
    logic [VPN_W-1:0] page_q;
    logic [PFN_W-1:0] frame_q;
    logic             fr_wr_q;
    logic             fr_v_q;
    logic [31:0]      bad_q;

    logic [IDX_W-1:0] rnd_idx;
    logic             lk_hit, lk_valid, lk_wr_ok, pr_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [IDX_W-1:0] pr_idx;
    tlb_entry_t       wr_data, rd_entry;
    logic             wr_en;
    tlb_op_e          op;
    exc_e             code;

    assign op      = tlb_op_e'(cmd_op);
    assign wr_en   = cmd_valid && (op == OP_WR_RAND || op == OP_WR_IDX);
    assign wr_data = '{vpn: page_q, pfn: frame_q, wr_ok: fr_wr_q, valid: fr_v_q};

    tlb_rand_ctr #(.N(SLOTS), .LOW(PINNED)) u_rnd (
        .clk(clk), .rst(rst), .idx(rnd_idx)
    );

    tlb_cam #(.N(SLOTS)) u_cam (
        .clk(clk), .rst(rst),
        .lk_vpn(acc_vaddr[31:PAGE_BITS]), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .lk_valid(lk_valid), .lk_wr_ok(lk_wr_ok),
        .pr_vpn(page_q), .pr_hit(pr_hit), .pr_idx(pr_idx),
        .wr_en(wr_en), .wr_idx(op == OP_WR_RAND ? rnd_idx : idx_q), .wr_data(wr_data),
        .rd_idx(idx_q), .rd_entry(rd_entry)
    );

    // fault classification in priority order, then address formation
    always_comb begin
        code      = EXC_NONE;
        acc_paddr = '0;
        acc_umiss = 1'b0;
        if (is_misaligned(acc_vaddr[1:0], acc_size)) begin
            code = EXC_ALIGN;
        end else if (acc_user && acc_vaddr[31]) begin
            code = EXC_PRIV;
        end else if (acc_vaddr[31:30] == 2'b11) begin
            acc_paddr = acc_vaddr[PA_W-1:0];
        end else if (!lk_hit) begin
            code      = EXC_MISS;
            acc_umiss = !acc_vaddr[31];
        end else if (!lk_valid) begin
            code = EXC_INVALID;
        end else if (acc_store && !lk_wr_ok) begin
            code = EXC_WPROT;
        end else begin
            acc_paddr = {lk_pfn, acc_vaddr[PAGE_BITS-1:0]};
        end
    end

    assign acc_fault = (code != EXC_NONE);
    assign acc_code  = code;

    always_ff @(posedge clk) begin
        if (rst) begin
            nf_q    <= 1'b0;
            idx_q   <= '0;
            page_q  <= '0;
            frame_q <= '0;
            fr_wr_q <= 1'b0;
            fr_v_q  <= 1'b0;
            bad_q   <= '0;
        end else if (cmd_valid) begin
            if (op == OP_PROBE) begin
                nf_q <= !pr_hit;
                if (pr_hit) idx_q <= pr_idx;
            end else if (op == OP_RD_IDX) begin
                page_q  <= rd_entry.vpn;
                frame_q <= rd_entry.pfn;
                fr_wr_q <= rd_entry.wr_ok;
                fr_v_q  <= rd_entry.valid;
            end
        end else if (sr_we) begin
            case (sr_sel_e'(sr_sel))
                SEL_INDEX: begin
                    nf_q  <= sr_wdata[31];
                    idx_q <= sr_wdata[IDX_W-1:0];
                end
                SEL_PAGE:  page_q <= sr_wdata[31:PAGE_BITS];
                SEL_FRAME: begin
                    frame_q <= sr_wdata[PA_W-1:PAGE_BITS];
                    fr_wr_q <= sr_wdata[1];
                    fr_v_q  <= sr_wdata[0];
                end
                default:   bad_q <= sr_wdata;
            endcase
        end else if (acc_valid && acc_fault) begin
            bad_q <= acc_vaddr;
            if (is_tlb_exc(code)) page_q <= acc_vaddr[31:PAGE_BITS];
        end
    end

    always_comb begin
        case (sr_sel_e'(sr_sel))
            SEL_INDEX: sr_rdata = {nf_q, {(31 - IDX_W){1'b0}}, idx_q};
            SEL_PAGE:  sr_rdata = {page_q, {PAGE_BITS{1'b0}}};
            SEL_FRAME: sr_rdata = {{(32 - PA_W){1'b0}}, frame_q, {(PAGE_BITS - 2){1'b0}}, fr_wr_q, fr_v_q};
            default:   sr_rdata = bad_q;
        endcase
    end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int IW  = tlb_pkg::IDX_W,
    parameter int LOW = tlb_pkg::PINNED
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic [31:0]   acc_vaddr,
    input logic [1:0]    acc_size,
    input logic          acc_user,
    input logic          acc_fault,
    input logic [4:0]    acc_code,
    input logic          acc_umiss,
    input logic          cmd_valid,
    input logic          sr_we,
    input logic [31:0]   bad_q,
    input logic [IW-1:0] rnd_idx
);
    logic mis;
    assign mis = (acc_size == 2'd1) ? acc_vaddr[0] :
                 (acc_size == 2'd0) ? 1'b0 : (acc_vaddr[1:0] != 2'b00);

    assert_align_code_R3: assert property (@(posedge clk) disable iff (rst)
        acc_valid && mis |-> acc_fault && acc_code == 5'd24);

    assert_user_priv_R4: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !mis && acc_user && acc_vaddr[31] |-> acc_code == 5'd25);

    assert_window_clean_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !mis && !acc_user && acc_vaddr[31:30] == 2'b11 |-> !acc_fault);

    assert_miss_half_R5: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_code == 5'd21 |-> acc_umiss == !acc_vaddr[31]);

    assert_fault_addr_R9: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_fault && !cmd_valid && !sr_we |=> bad_q == $past(acc_vaddr));

    assert_rand_slot_R12: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rnd_idx >= IW'(LOW));
endmodule

bind mmu_xlate mmu_xlate_chk #(.IW(tlb_pkg::IDX_W), .LOW(tlb_pkg::PINNED)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_size(acc_size), .acc_user(acc_user), .acc_fault(acc_fault),
    .acc_code(acc_code), .acc_umiss(acc_umiss), .cmd_valid(cmd_valid),
    .sr_we(sr_we), .bad_q(bad_q), .rnd_idx(rnd_idx)
);

// File: tb/mmu_xlate_tb.sv
`timescale 1ns/1ps
module mmu_xlate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic        acc_store = 1'b0;
    logic [1:0]  acc_size = 2'd2;
    logic        acc_user = 1'b0;
    logic [29:0] acc_paddr;
    logic        acc_fault;
    logic [4:0]  acc_code;
    logic        acc_umiss;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_sel = '0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [19:0] m_vpn [32];
    logic [31:0] m_lo  [32];

    always #2.5 clk = ~clk;

    mmu_xlate u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .acc_store(acc_store), .acc_size(acc_size), .acc_user(acc_user),
        .acc_paddr(acc_paddr), .acc_fault(acc_fault), .acc_code(acc_code),
        .acc_umiss(acc_umiss), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] vpn_of(input int i);
        return (i[2] ? 20'h80100 : 20'h00100) + 20'(i);
    endfunction

    function automatic logic [31:0] lo_of(input int i);
        return ((32'h3000 + 32'(i)) << 12) | 32'(i & 3);
    endfunction

    task automatic model(input logic [31:0] va, input logic st, input logic [1:0] sz,
                         input logic us, output logic [4:0] c, output logic [31:0] pa,
                         output logic um);
        logic mis;
        int hit;
        c = 0; pa = 0; um = 0; hit = -1;
        mis = (sz == 0) ? 1'b0 : (sz == 1) ? va[0] : (va % 4 != 0);
        if (mis) c = 24;
        else if (us && va >= 32'h80000000) c = 25;
        else if (va >= 32'hC0000000) begin
            if (va < 32'hE0000000)      pa = va - 32'hC0000000;
            else if (va < 32'hF0000000) pa = va - 32'hE0000000 + 32'h20000000;
            else                        pa = va - 32'hF0000000 + 32'h30000000;
        end else begin
            for (int i = 31; i >= 0; i--) if (m_vpn[i] == va[31:12]) hit = i;
            if (hit < 0) begin c = 21; um = (va < 32'h80000000); end
            else if (!m_lo[hit][0]) c = 23;
            else if (st && !m_lo[hit][1]) c = 22;
            else pa = {2'b00, m_lo[hit][29:12], va[11:0]};
        end
    endtask

    task automatic access(input logic [31:0] va, input logic st, input logic [1:0] sz,
                          input logic us, input string req);
        logic [4:0] c; logic [31:0] pa; logic um;
        model(va, st, sz, us, c, pa, um);
        @(negedge clk);
        acc_vaddr = va; acc_store = st; acc_size = sz; acc_user = us; acc_valid = 1'b1;
        #1;
        check({req, " code"}, {27'b0, acc_code}, {27'b0, c});
        check({req, " fault"}, {31'b0, acc_fault}, {31'b0, (c != 0)});
        check({req, " paddr"}, {2'b0, acc_paddr}, pa);
        check({req, " umiss"}, {31'b0, acc_umiss}, {31'b0, um});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_sel = sel; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        sr_sel = sel;
        #1;
        v = sr_rdata;
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            m_vpn[i] = 20'hC0000 + 20'(i);
            m_lo[i]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reset register", v, 0);
        end
        access(32'h00000000, 0, 2, 0, "R1 miss after reset low");
        access(32'hBFFFF000, 0, 2, 0, "R1 miss after reset high");

        // R11: fill every slot by index, read back each one
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'(i));
            wr(1, {vpn_of(i), 12'h0});
            wr(2, lo_of(i));
            cmd(2'd3);
            m_vpn[i] = vpn_of(i);
            m_lo[i]  = lo_of(i);
        end
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'(i));
            wr(1, 0);
            wr(2, 0);
            cmd(2'd2);
            rd(1, v); check("R11 read-indexed page", v, {vpn_of(i), 12'h0});
            rd(2, v); check("R11 read-indexed frame", v, lo_of(i));
        end

        // R6 R7 R8 R4: load, store and user load through every slot
        for (int i = 0; i < 32; i++) begin
            logic [31:0] va;
            va = {vpn_of(i), 12'((i * 32'h44) & 32'hFFC)};
            access(va, 0, 2, 0, "R8 R6 kernel load");
            access(va, 1, 2, 0, "R7 R6 kernel store");
            access(va, 0, 2, 1, "R4 user load");
        end

        // R10: probe hits for each slot
        for (int i = 0; i < 32; i++) begin
            wr(1, {vpn_of(i), 12'h0});
            cmd(2'd0);
            rd(0, v); check("R10 probe hit", v, 32'(i));
        end
        wr(1, 32'h55555000);
        cmd(2'd0);
        rd(0, v); check("R10 probe miss bit31", v & 32'h80000000, 32'h80000000);

        // R3: every size against every low address pair, on a writable valid user page
        for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 4; lo++)
                access({vpn_of(3), 12'h100 + 12'(lo)}, 1, 2'(sz), 1, "R3 alignment sweep");
        access(32'hF0000001, 0, 1, 1, "R3 before R4 priority");
        access(32'h55555002, 0, 2, 0, "R3 before R5 priority");

        // R2: window edges
        access(32'hC0000000, 0, 2, 0, "R2 RAM base");
        access(32'hDFFFFFFC, 1, 2, 0, "R2 RAM top");
        access(32'hE0000010, 0, 2, 0, "R2 ROM");
        access(32'hEFFFFFFF, 0, 0, 0, "R2 ROM top");
        access(32'hF0000004, 1, 2, 0, "R2 IO");
        access(32'hFFFFFFFC, 0, 2, 0, "R2 IO top");

        // R5 R9: miss captures and non-table faults
        access(32'h12345678, 0, 2, 1, "R5 user-half miss");
        rd(3, v); check("R9 fault address after miss", v, 32'h12345678);
        rd(1, v); check("R9 page after miss", v, 32'h12345000);
        access(32'hA2345670, 0, 2, 0, "R5 kernel-half miss");
        rd(1, v); check("R9 page after kernel miss", v, 32'hA2345000);
        access(32'h00000003, 0, 2, 0, "R9 align fault");
        rd(3, v); check("R9 fault address after align", v, 32'h00000003);
        rd(1, v); check("R9 page kept after align", v, 32'hA2345000);
        access(32'h80000000, 0, 2, 1, "R9 priv fault");
        rd(1, v); check("R9 page kept after priv", v, 32'hA2345000);
        access({vpn_of(0), 12'h040}, 0, 2, 0, "R9 invalid fault");
        rd(1, v); check("R9 page after invalid", v, {vpn_of(0), 12'h0});
        rd(3, v); check("R9 fault address after invalid", v, {vpn_of(0), 12'h040});

        // R8: duplicate page, lowest slot wins
        wr(0, 32'd20);
        wr(1, {vpn_of(7), 12'h0});
        wr(2, 32'h00ABC003);
        cmd(2'd3);
        m_vpn[20] = vpn_of(7);
        m_lo[20]  = 32'h00ABC003;
        access({vpn_of(7), 12'h008}, 0, 2, 0, "R8 lowest slot wins");

        // R12: write-random never lands in pinned slots
        for (int k = 0; k < 40; k++) begin
            wr(1, (32'h40000 + 32'(k)) << 12);
            wr(2, ((32'h100 + 32'(k)) << 12) | 32'h3);
            repeat (k % 3) @(negedge clk);
            cmd(2'd1);
            cmd(2'd0);
            rd(0, v);
            check("R12 random slot in range", {31'b0, (v[31] == 1'b0 && v[4:0] >= 5'd4)}, 1);
        end
        for (int i = 0; i < 4; i++) begin
            wr(1, {vpn_of(i), 12'h0});
            cmd(2'd0);
            rd(0, v); check("R12 pinned slot kept", v, 32'(i));
        end
        m_vpn[0] = 20'h40027;
        m_lo[0]  = ((32'h100 + 32'd39) << 12) | 32'h3;
        access(32'h40027ABC, 1, 0, 0, "R12 random entry translates");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule